// File: doc/BRIEF.md
# Masked Port Change Interrupt Detector

This block watches the upper half of an 8-bit input port and raises an interrupt request when any watched pin changes level. The port is first passed through a multi-stage synchronizer. Each watched pin has its own enable bit in a mask register. The block keeps a latched copy of each enabled pin's level and compares it with the synchronized level on every cycle. A rising or a falling difference on any enabled pin sets one shared change flag. The flag stays set until software clears it.

A source-enable bit decides whether a set flag produces a request. A priority bit sends that request either to the high-priority output or to the low-priority output. Software uses a small register port to set up the block and to clear the flag. It can also read back the latched pin levels to find out which pins moved.

The flag is held by a two-state machine:
- `FLG_IDLE` means no change is pending. The transition *detect* (an enabled pin differs from its latched level) moves it to `FLG_PEND`.
- `FLG_PEND` means a change is pending. The transition *acknowledge* (a clear write in a cycle with no new change) returns it to `FLG_IDLE`.
- Every other case stays in the same state.

Top module: `pchg_irq_top`

## Requirements
- R1: Only port bits 7 to 4 are watched. Toggling port bits 3 to 0 never sets the flag and never changes the level read-back.
- R2: Both a rising and a falling level change on an enabled watched pin set the flag. The flag is visible on the third rising clock edge after the input changes, because the path is two synchronizer stages plus the flag register.
- R3: A watched pin whose mask bit is 0 cannot set the flag. Its latched level holds while the mask bit stays 0.
- R4: Address 0 bit 0 is the source enable. While it is 0, both `irq_hi` and `irq_lo` are low, even when the flag is set.
- R5: Address 0 bit 1 is the priority bit. When the flag and the enable are both set, a priority of 1 drives `irq_hi`, and a priority of 0 drives `irq_lo`. The two outputs are never high together.
- R6: Address 2 bit 0 reads the flag. Writing 1 to that bit clears the flag on the next edge. Writing 0 to it has no effect.
- R7: The flag is sticky and stays set until it is cleared. If a clear arrives in the same cycle as a detected change, the flag stays set.
- R8: Address 3 bits 3 to 0 read the latched levels of port bits 7 to 4, with bit i holding port bit 4+i. Enabled pins track the synchronized input.
- R9: Address 1 bits 3 to 0 are the mask, with bit i enabling port bit 4+i. Writing a 1 to a mask bit that was 0 loads that pin's latched level from its current synchronized level, and this load does not set the flag.
- R10: After reset, every register reads 0, the flag is clear and both request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_in | input | 8 | Asynchronous input port |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for both read and write |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, combinational from `addr` |
| irq_hi | output | 1 | High-priority interrupt request |
| irq_lo | output | 1 | Low-priority interrupt request |

## Verification
A wrong latched level shows up in two ways:
- In the level read-back register on the very next cycle.
- As a spurious or missing flag exactly three edges after an input change.

A flag machine stuck in the wrong state shows in the status bit and in the request outputs on the cycle after the faulty transition.

The scenarios place a clear write on the exact edge where a change is detected, so that a mis-ordered priority between clear and set is exposed. They also enable a mask bit on a pin whose level differs from its stale history, so that a missing history load is exposed.

// File: rtl/pchg_pkg.sv
package pchg_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] A_MASK  = 2'd1;
    localparam logic [ADDR_W-1:0] A_STAT  = 2'd2;
    localparam logic [ADDR_W-1:0] A_LEVEL = 2'd3;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_PRIO_BIT = 1;
    localparam int STAT_FLAG_BIT = 0;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flg_state_e;

    typedef struct packed {
        logic en;
        logic prio;
    } ctrl_t;
endpackage

// File: rtl/pchg_sync.sv
module pchg_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] st;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[0] <= '0;
        else        st[0] <= d;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[k] <= '0;
            else        st[k] <= st[k-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/pchg_detect.sv
module pchg_detect #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] mask_load,
    output logic [W-1:0] hist,
    output logic         chg_any
);
    logic [W-1:0] diff;

    for (genvar i = 0; i < W; i++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     hist[i] <= 1'b0;
            else if (mask_load[i] || mask[i]) hist[i] <= lvl[i];
        end

        assign diff[i] = mask[i] & (lvl[i] ^ hist[i]);

        // R3: a disabled pin keeps its history unless the enable write loads it
        p_masked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!mask[i] && !mask_load[i]) |=> $stable(hist[i]));
    end

    assign chg_any = |diff;
endmodule

// File: rtl/pchg_flag.sv
module pchg_flag
    import pchg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chg_any,
    input  logic clr,
    input  logic en,
    input  logic prio,
    output logic flag,
    output logic irq_hi,
    output logic irq_lo
);
    flg_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (chg_any)         state_d = FLG_PEND;
            FLG_PEND: if (clr && !chg_any) state_d = FLG_IDLE;
            default:                       state_d = FLG_IDLE;
        endcase
    end

    always_comb begin
        flag   = (state_q == FLG_PEND);
        irq_hi = flag & en & prio;
        irq_lo = flag & en & ~prio;
    end

    p_detect_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        chg_any |=> flag);
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !chg_any) |=> !flag);
endmodule

// File: rtl/pchg_regs.sv
module pchg_regs
    import pchg_pkg::*;
#(
    parameter int MON_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              flag,
    input  logic [MON_W-1:0]  hist,
    output ctrl_t             ctrl,
    output logic [MON_W-1:0]  mask,
    output logic [MON_W-1:0]  mask_load,
    output logic              clr,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD_W = DATA_W - MON_W;

    logic unused_wdata;
    assign unused_wdata = ^wdata[DATA_W-1:MON_W];

    logic wr_ctrl, wr_mask;
    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign wr_mask = wr_en && (addr == A_MASK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
            mask <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.en   <= wdata[CTRL_EN_BIT];
                ctrl.prio <= wdata[CTRL_PRIO_BIT];
            end
            if (wr_mask) mask <= wdata[MON_W-1:0];
        end
    end

    assign mask_load = wr_mask ? (wdata[MON_W-1:0] & ~mask) : '0;
    assign clr       = wr_en && (addr == A_STAT) && wdata[STAT_FLAG_BIT];

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL:  begin
                rdata[CTRL_EN_BIT]   = ctrl.en;
                rdata[CTRL_PRIO_BIT] = ctrl.prio;
            end
            A_MASK:  rdata = {{PAD_W{1'b0}}, mask};
            A_STAT:  rdata[STAT_FLAG_BIT] = flag;
            A_LEVEL: rdata = {{PAD_W{1'b0}}, hist};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/pchg_irq_top.sv
module pchg_irq_top
    import pchg_pkg::*;
#(
    parameter int PORT_W      = 8,
    parameter int MON_LSB     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_hi,
    output logic              irq_lo
);
    localparam int MON_W = PORT_W - MON_LSB;

    logic unused_low;
    assign unused_low = ^port_in[MON_LSB-1:0];

    logic [MON_W-1:0] lvl, hist, mask, mask_load;
    logic             chg_any, clr, flag;
    ctrl_t            ctrl;

    pchg_sync #(.W(MON_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(port_in[PORT_W-1:MON_LSB]), .q(lvl)
    );

    pchg_detect #(.W(MON_W)) u_det (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .mask(mask),
        .mask_load(mask_load), .hist(hist), .chg_any(chg_any)
    );

    pchg_regs #(.MON_W(MON_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .flag(flag), .hist(hist), .ctrl(ctrl), .mask(mask),
        .mask_load(mask_load), .clr(clr), .rdata(rdata)
    );

    pchg_flag u_flag (
        .clk(clk), .rst_n(rst_n), .chg_any(chg_any), .clr(clr),
        .en(ctrl.en), .prio(ctrl.prio), .flag(flag),
        .irq_hi(irq_hi), .irq_lo(irq_lo)
    );

    p_one_output_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_hi && irq_lo));
    p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.en |-> (!irq_hi && !irq_lo));
    p_enable_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|mask_load && !chg_any) |=> !chg_any || (lvl != $past(lvl)));
endmodule

// File: tb/tb_pchg_irq_top.sv
module tb_pchg_irq_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] port_in = 8'h00;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq_hi, irq_lo;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pchg_irq_top dut (
        .clk(clk), .rst_n(rst_n), .port_in(port_in), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_hi(irq_hi), .irq_lo(irq_lo)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = 8'h00;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic drive(input logic [7:0] v);
        @(negedge clk);
        port_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            chk("R10 reg after reset", v, 8'h00);
        end
        chk("R10 irq_hi after reset", {7'd0, irq_hi}, 8'h00);
        chk("R10 irq_lo after reset", {7'd0, irq_lo}, 8'h00);
    endtask

    task automatic t_rise();
        logic [7:0] v;
        wr(2'd0, 8'h03);
        wr(2'd1, 8'h01);
        @(negedge clk); port_in = 8'h10;
        @(negedge clk); @(negedge clk);
        #1 chk("R2 flag not before third edge", {7'd0, irq_hi}, 8'h00);
        @(negedge clk);
        #1 chk("R2 flag on third edge", {7'd0, irq_hi}, 8'h01);
        rd(2'd2, v); chk("R2 rising sets flag", v, 8'h01);
        chk("R5 high priority routes to irq_hi", {6'd0, irq_hi, irq_lo}, 8'h02);
        rd(2'd3, v); chk("R8 levels after rise", v, 8'h01);
        wr(2'd2, 8'h01);
        rd(2'd2, v); chk("R6 clear write", v, 8'h00);
        chk("R6 irq drops after clear", {7'd0, irq_hi}, 8'h00);
    endtask

    task automatic t_fall();
        logic [7:0] v;
        drive(8'h00);
        rd(2'd2, v); chk("R2 falling sets flag", v, 8'h01);
        wr(2'd2, 8'h00);
        rd(2'd2, v); chk("R6 write of 0 keeps flag", v, 8'h01);
        wr(2'd2, 8'h01);
        rd(2'd3, v); chk("R8 levels after fall", v, 8'h00);
    endtask

    task automatic t_prio();
        logic [7:0] v;
        wr(2'd0, 8'h01);
        drive(8'h10);
        rd(2'd2, v);
        chk("R5 low priority routes to irq_lo", {6'd0, irq_hi, irq_lo}, 8'h01);
        wr(2'd0, 8'h00);
        rd(2'd2, v); chk("R4 flag kept with enable off", v, 8'h01);
        chk("R4 both outputs low", {6'd0, irq_hi, irq_lo}, 8'h00);
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h03);
    endtask

    task automatic t_low();
        logic [7:0] v;
        drive(8'h1F);
        drive(8'h15);
        rd(2'd2, v); chk("R1 low nibble ignored flag", v, 8'h00);
        rd(2'd3, v); chk("R1 low nibble ignored levels", v, 8'h01);
        drive(8'h10);
    endtask

    task automatic t_masked();
        logic [7:0] v;
        drive(8'h30);
        rd(2'd2, v); chk("R3 masked pin no flag", v, 8'h00);
        rd(2'd3, v); chk("R3 masked pin level held", v, 8'h01);
    endtask

    task automatic t_mask_en();
        logic [7:0] v;
        wr(2'd1, 8'h03);
        repeat (4) @(negedge clk);
        rd(2'd2, v); chk("R9 enabling mask no flag", v, 8'h00);
        rd(2'd3, v); chk("R9 history loaded on enable", v, 8'h03);
        rd(2'd1, v); chk("R9 mask read back", v, 8'h03);
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        @(negedge clk); port_in = 8'h20;
        @(negedge clk); @(negedge clk);
        wr_en = 1'b1; addr = 2'd2; wdata = 8'h01;
        @(negedge clk);
        wr_en = 1'b0; wdata = 8'h00;
        rd(2'd2, v); chk("R7 change wins over clear", v, 8'h01);
        repeat (6) @(negedge clk);
        rd(2'd2, v); chk("R7 flag sticky", v, 8'h01);
        wr(2'd2, 8'h01);
        rd(2'd2, v); chk("R6 clear after sticky", v, 8'h00);
        rd(2'd3, v); chk("R8 levels after fall on bit4", v, 8'h02);
    endtask

    task automatic t_multi();
        logic [7:0] v;
        drive(8'hD0);
        rd(2'd2, v); chk("R2 multi-pin change sets flag", v, 8'h01);
        rd(2'd3, v); chk("R8 levels multi-pin", v, 8'h01);
        wr(2'd2, 8'h01);
        wr(2'd1, 8'h0F);
        repeat (4) @(negedge clk);
        rd(2'd2, v); chk("R9 enable upper pins no flag", v, 8'h00);
        rd(2'd3, v); chk("R9 upper pins loaded", v, 8'h0D);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rise();
        t_fall();
        t_prio();
        t_low();
        t_masked();
        t_mask_en();
        t_same_cycle();
        t_multi();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule